// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt request lines into a request register. Devices report each line through one-cycle set and clear events. The block keeps the last level it saw on each line, so it can tell a fresh assertion from a repeated one. A per-line sense-mode byte picks edge or level behaviour for each line. The mode decides two things: when a set event latches a request, and whether a clear event withdraws one.

Two more inputs act on the request register:
- An acknowledge clear mask, driven by the downstream priority resolver, drops the request bits that have just been serviced.
- An initialization pulse empties the request register and the remembered levels together.

The outputs are the request register, the remembered levels and the sense-mode byte. Priority resolution and command decoding live elsewhere.

Top module: `irq_req_latch`

## Requirements
- R1: In edge mode (sense-mode bit = 0), a set event latches the line's request bit only when the line's remembered level is low. A set while the level is already high leaves the request bit unchanged.
- R2: In level mode (sense-mode bit = 1), a set event always latches the line's request bit, even when the remembered level is already high.
- R3: Every set event makes the line's remembered level high in the next cycle.
- R4: A clear event without a same-cycle set makes the remembered level low. It also drops the request bit in level mode only. In edge mode the request bit persists.
- R5: The sense-mode byte is written as a whole by `mode_we_i`/`mode_wdata_i` and read back on `mode_o` from the next cycle. Bit i = 1 puts line i in level mode. Events in the write cycle itself use the old mode.
- R6: `init_i` clears every request bit and every remembered level in the next cycle. It overrides same-cycle set events and leaves the sense-mode byte unchanged.
- R7: A 1 in `ack_clr_i` bit i clears request bit i in the next cycle. The exception is a same-cycle set that latches line i: the latching set wins and the bit stays 1.
- R8: After the asynchronous reset, the request register, the remembered levels and the sense-mode byte are all 0, so every line is in edge mode.
- R9: When a set and a clear arrive on the same line in the same cycle, the set wins and the clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_i | input | 8 | Per-line set events (line asserted) |
| clr_i | input | 8 | Per-line clear events (line deasserted) |
| ack_clr_i | input | 8 | Acknowledge clear mask from the resolver |
| init_i | input | 1 | Initialization: clear requests and remembered levels |
| mode_we_i | input | 1 | Sense-mode byte write enable |
| mode_wdata_i | input | 8 | Sense-mode byte write data |
| mode_o | output | 8 | Sense-mode byte (1 = level mode) |
| req_o | output | 8 | Request register |
| level_o | output | 8 | Remembered input levels |

## Verification
The hardest situations to reach need several events on one line in one cycle, each against a particular history:
- an acknowledge racing a set that either does or does not latch, depending on the mode and the remembered level;
- a set racing a clear;
- a sense-mode write racing a set on the line whose mode is changing.

The stimulus first builds the needed history: a line left high, or an edge-mode request left standing after its line dropped. It then drives the competing events together in one vector, and checks the request, level and mode bytes in the following cycle.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned NUM_LINES_DEF = 8;

  typedef struct packed {
    logic set;
    logic clr;
    logic ack;
    logic init;
  } line_evt_t;
endpackage

// File: rtl/irq_latch_mode_reg.sv
module irq_latch_mode_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mode_o
);
  logic [WIDTH-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= wdata_i;
  end

  assign mode_o = mode_q;

  AST_MODE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mode_q == $past(wdata_i))); // R5
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_q)); // R5
endmodule

// File: rtl/irq_latch_cell.sv
module irq_latch_cell
  import irq_latch_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_evt_t evt_i,
  input  logic      lvl_mode_i,
  output logic      req_o,
  output logic      level_o
);
  logic req_q, level_q;
  logic req_d, level_d;
  logic latch;

  always_comb begin
    latch   = 1'b0;
    req_d   = req_q;
    level_d = level_q;
    if (evt_i.init) begin
      req_d   = 1'b0;
      level_d = 1'b0;
    end else begin
      if (evt_i.set) begin
        level_d = 1'b1;
        latch   = lvl_mode_i || !level_q;
      end else if (evt_i.clr) begin
        level_d = 1'b0;
        if (lvl_mode_i) req_d = 1'b0;
      end
      if (latch)          req_d = 1'b1;
      else if (evt_i.ack) req_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      level_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      level_q <= level_d;
    end
  end

  assign req_o   = req_q;
  assign level_o = level_q;

  AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.set && !evt_i.init && !lvl_mode_i && !level_q) |=> req_q); // R1
  AST_EDGE_NO_RELATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.set && !evt_i.init && !lvl_mode_i && level_q && !evt_i.ack) |=> $stable(req_q)); // R1
  AST_LEVEL_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.set && !evt_i.init && lvl_mode_i) |=> req_q); // R2
  AST_SET_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.set && !evt_i.init) |=> level_q); // R3
  AST_CLR_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.clr && !evt_i.set && !evt_i.init) |=> !level_q); // R4
  AST_CLR_LVL_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.clr && !evt_i.set && !evt_i.init && lvl_mode_i) |=> !req_q); // R4
  AST_EDGE_PERSIST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.clr && !evt_i.set && !evt_i.init && !evt_i.ack && !lvl_mode_i) |=> $stable(req_q)); // R4
  AST_INIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.init |=> (!req_q && !level_q)); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.ack && !evt_i.set) |=> !req_q); // R7
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_LINES = NUM_LINES_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic [NUM_LINES-1:0] ack_clr_i,
  input  logic                 init_i,
  input  logic                 mode_we_i,
  input  logic [NUM_LINES-1:0] mode_wdata_i,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] req_o,
  output logic [NUM_LINES-1:0] level_o
);
  logic [NUM_LINES-1:0] mode;

  irq_latch_mode_reg #(.WIDTH(NUM_LINES)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_evt_t evt;
    assign evt = '{set: set_i[g], clr: clr_i[g], ack: ack_clr_i[g], init: init_i};
    irq_latch_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt),
      .lvl_mode_i (mode[g]),
      .req_o      (req_o[g]),
      .level_o    (level_o[g])
    );
  end

  assign mode_o = mode;

  AST_SET_OVER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && |(set_i & clr_i)) |=> ((level_o & $past(set_i & clr_i)) == $past(set_i & clr_i))); // R9
  AST_RESET_STATE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (req_o == '0 && level_o == '0 && mode_o == '0)); // R8
endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  localparam int N = 8;
  localparam int NV = 16;
  // {we, wdata, set, clr, ack, init, exp_req, exp_lvl, exp_mode}
  localparam logic [57:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 8'h01, 8'h01, 8'h00}, // R1 first edge
    {1'b0, 8'h00, 8'h01, 8'h00, 8'h01, 1'b0, 8'h00, 8'h01, 8'h00}, // R1 R7 no relatch, ack clears
    {1'b0, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00}, // R4 level drop
    {1'b0, 8'h00, 8'h03, 8'h00, 8'h00, 1'b0, 8'h03, 8'h03, 8'h00}, // R3
    {1'b0, 8'h00, 8'h00, 8'h03, 8'h00, 1'b0, 8'h03, 8'h00, 8'h00}, // R4 edge persists
    {1'b1, 8'hF0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h03, 8'h00, 8'hF0}, // R5 write
    {1'b0, 8'h00, 8'h30, 8'h00, 8'h00, 1'b0, 8'h33, 8'h30, 8'hF0}, // R2
    {1'b0, 8'h00, 8'h10, 8'h00, 8'h10, 1'b0, 8'h33, 8'h30, 8'hF0}, // R2 R7 set beats ack
    {1'b0, 8'h00, 8'h00, 8'h20, 8'h00, 1'b0, 8'h13, 8'h10, 8'hF0}, // R4 level clears
    {1'b0, 8'h00, 8'h00, 8'h00, 8'h03, 1'b0, 8'h10, 8'h10, 8'hF0}, // R7 ack mask
    {1'b0, 8'h00, 8'h40, 8'h40, 8'h00, 1'b0, 8'h50, 8'h50, 8'hF0}, // R9 level line
    {1'b0, 8'h00, 8'h04, 8'h04, 8'h00, 1'b0, 8'h54, 8'h54, 8'hF0}, // R9 edge line
    {1'b0, 8'h00, 8'h08, 8'h00, 8'h00, 1'b1, 8'h00, 8'h00, 8'hF0}, // R6 init wins, mode kept
    {1'b1, 8'h0F, 8'h80, 8'h00, 8'h00, 1'b0, 8'h80, 8'h80, 8'h0F}, // R5 old mode used
    {1'b0, 8'h00, 8'h80, 8'h00, 8'h80, 1'b0, 8'h00, 8'h80, 8'h0F}, // R7 non-latching set
    {1'b0, 8'h00, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00, 8'h80, 8'h0F}  // R1 high edge no latch
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] set_i = '0, clr_i = '0, ack_clr_i = '0, mode_wdata_i = '0;
  logic init_i = 1'b0, mode_we_i = 1'b0;
  logic [N-1:0] mode_o, req_o, level_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_req_latch #(.NUM_LINES(N)) u_dut (
    .clk_i, .rst_ni, .set_i, .clr_i, .ack_clr_i, .init_i,
    .mode_we_i, .mode_wdata_i, .mode_o, .req_o, .level_o
  );

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s req/lvl/mode act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(logic we, logic [7:0] wd, logic [7:0] s, logic [7:0] c,
                      logic [7:0] a, logic in);
    @(negedge clk_i);
    mode_we_i = we; mode_wdata_i = wd; set_i = s; clr_i = c; ack_clr_i = a; init_i = in;
    @(posedge clk_i);
    #1;
    mode_we_i = 1'b0; set_i = '0; clr_i = '0; ack_clr_i = '0; init_i = 1'b0;
  endtask

  initial begin
    #7;
    check("R8 during reset", {req_o, level_o, mode_o}, 24'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 after reset", {req_o, level_o, mode_o}, 24'h0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][57], VEC[i][56:49], VEC[i][48:41], VEC[i][40:33], VEC[i][32:25], VEC[i][24]);
      check($sformatf("vector %0d (R1..R9 table)", i), {req_o, level_o, mode_o}, VEC[i][23:0]);
    end
    step(1'b1, 8'hA5, 8'h00, 8'h00, 8'h00, 1'b0);
    check("R5 readback A5", {8'h00, 8'h00, mode_o}, 24'h0000A5);
    step(1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0);
    check("R2 R3 all lines", {req_o, level_o, mode_o}, 24'hFFFFA5);
    step(1'b0, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0);
    check("R4 mixed modes", {req_o, level_o, mode_o}, 24'h5A00A5);
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    check("R8 async reset", {req_o, level_o, mode_o}, 24'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    step(1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0);
    check("R8 edge mode after reset", {req_o, level_o, mode_o}, 24'h010100);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule